// File: doc/BRIEF.md
# Serial Read-Only Memory Slave Port

This block is the target side of a four-wire serial bus in front of a byte-wide read-only array of 2M locations. A bus master lowers the select line and clocks in an 8-bit read command. It then clocks in a 24-bit start address. From the next serial clock falling edge onward, the block returns bytes from consecutive addresses, most significant bit first, for as long as the master keeps clocking. Raising the select line ends the transfer at any point.

All bus pins are brought into the core clock domain through synchronizer stages, and serial clock edges are found by comparing successive samples. The serial clock must therefore run well below the core clock. Either idle level of the serial clock is accepted. A pause input from a neighbouring block freezes the transfer in place and releases the output. The array contents are computed from the address by a fixed function, so the block needs no stored table.

Top module: `spi_rom_reader`

## Requirements
- R1: While `cs_ni` is high (seen through the synchronizer), `sdo_oe_o` is low and any partly received command or running read is dropped. A new transfer starts from the command phase.
- R2: After reset, the block accepts no command until it has seen `cs_ni` high and then low. Commands clocked while `cs_ni` stayed low since reset leave `sdo_oe_o` low.
- R3: `sdi_i` is sampled on rising `sclk_i` edges, most significant bit first. The read command is the byte 0x03 and is followed by a 24-bit address.
- R4: After any command byte other than 0x03, `sdo_oe_o` stays low for the rest of the transfer.
- R5: The first data bit appears after the first falling `sclk_i` edge that follows the last address bit. Each data byte is sent most significant bit first, `sdo_o` changes only after falling edges, and `sdo_oe_o` is high while data bits are sent.
- R6: Only the low 21 address bits select a byte. Address bits 23..21 have no effect on the data returned.
- R7: After each byte the address advances by one, and reading continues for as long as `sclk_i` toggles.
- R8: The address after 0x1FFFFF is 0x000000.
- R9: Operation is identical with `sclk_i` idling low and with `sclk_i` idling high.
- R10: While `pause_i` is high, `sclk_i` edges are neither sampled nor counted, `sdo_oe_o` is low, and the output bit position and `sdo_o` are held.
- R11: The byte at address a is a[7:0] ^ a[15:8] ^ {3'b000, a[20:16]} ^ 8'h5A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Bus select, active low |
| sclk_i | input | 1 | Serial clock from the master |
| sdi_i | input | 1 | Serial data from the master |
| pause_i | input | 1 | Transfer pause, synchronous to clk_i |
| sdo_o | output | 1 | Serial data to the master |
| sdo_oe_o | output | 1 | Output enable for sdo_o at the pad |

## Verification
The checks assume that `sclk_i`, `cs_ni` and `sdi_i` each hold for several core clocks between changes. They also assume that `pause_i` is synchronous to the core clock and changes only after the synchronizer has settled on the latest serial clock level. The stimulus uses serial half-periods of eight core clocks. It drives every input on falling core clock edges. It raises and lowers the pause several cycles after the nearest serial clock edge, and it ends every paused stretch at the serial clock level that was present when the pause began.

// File: rtl/spi_rom_pkg.sv
package spi_rom_pkg;
  localparam int unsigned CMD_W = 8;
  localparam int unsigned ADR_W = 24;

  typedef enum logic [1:0] {
    PH_CMD,
    PH_ADDR,
    PH_DATA,
    PH_SKIP
  } phase_e;
endpackage

// File: rtl/spi_rom_sync.sv
module spi_rom_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/spi_rom_array.sv
module spi_rom_array #(
  parameter int unsigned MEM_AW = 21,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [MEM_AW-1:0] addr_i,
  output logic [DATA_W-1:0] data_o
);
  localparam logic [DATA_W-1:0] SEED = DATA_W'(8'h5A);

  // contents: seed xor every DATA_W-wide slice of the address
  function automatic logic [DATA_W-1:0] rom_byte(input logic [MEM_AW-1:0] a);
    logic [DATA_W-1:0] v;
    v = SEED;
    for (int i = 0; i < int'(MEM_AW); i += int'(DATA_W)) v ^= DATA_W'(a >> i);
    return v;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) data_o <= '0;
    else         data_o <= rom_byte(addr_i);
endmodule

// File: rtl/spi_rom_engine.sv
module spi_rom_engine
  import spi_rom_pkg::*;
#(
  parameter int unsigned       MEM_AW = 21,
  parameter int unsigned       DATA_W = 8,
  parameter logic [CMD_W-1:0]  RD_OP  = 8'h03,
  localparam int unsigned      BP_W   = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              sdi_i,
  input  logic [DATA_W-1:0] rom_data_i,
  output logic [MEM_AW-1:0] rom_addr_o,
  output logic              out_bit_o,
  output logic              streaming_o,
  output logic [BP_W-1:0]   bit_pos_o
);
  localparam int unsigned CNT_W = $clog2(ADR_W);

  phase_e             phase_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [ADR_W-1:0]   shreg_q;
  logic [ADR_W-1:0]   shift_nxt;
  logic [DATA_W-1:0]  out_sr_q;
  logic [BP_W-1:0]    bit_pos_q;
  logic [MEM_AW-1:0]  addr_q;
  logic               started_q;

  assign shift_nxt = {shreg_q[ADR_W-2:0], sdi_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q   <= PH_SKIP;
      cnt_q     <= '0;
      shreg_q   <= '0;
      out_sr_q  <= '0;
      bit_pos_q <= '0;
      addr_q    <= '0;
      started_q <= 1'b0;
    end else if (clear_i) begin
      phase_q   <= PH_CMD;
      cnt_q     <= '0;
      out_sr_q  <= '0;
      bit_pos_q <= '0;
      started_q <= 1'b0;
    end else begin
      unique case (phase_q)
        PH_CMD: if (rise_i) begin
          shreg_q <= shift_nxt;
          if (cnt_q == CNT_W'(CMD_W - 1)) begin
            cnt_q   <= '0;
            phase_q <= (shift_nxt[CMD_W-1:0] == RD_OP) ? PH_ADDR : PH_SKIP;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_ADDR: if (rise_i) begin
          shreg_q <= shift_nxt;
          if (cnt_q == CNT_W'(ADR_W - 1)) begin
            cnt_q   <= '0;
            addr_q  <= shift_nxt[MEM_AW-1:0];
            phase_q <= PH_DATA;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_DATA: if (fall_i) begin
          if (bit_pos_q == '0) begin
            out_sr_q  <= rom_data_i;
            addr_q    <= addr_q + 1'b1;
            started_q <= 1'b1;
          end else begin
            out_sr_q <= out_sr_q << 1;
          end
          bit_pos_q <= (bit_pos_q == BP_W'(DATA_W - 1)) ? '0 : bit_pos_q + 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign rom_addr_o  = addr_q;
  assign out_bit_o   = out_sr_q[DATA_W-1];
  assign streaming_o = started_q && (phase_q == PH_DATA);
  assign bit_pos_o   = bit_pos_q;
endmodule

// File: rtl/spi_rom_reader.sv
module spi_rom_reader
  import spi_rom_pkg::*;
#(
  parameter int unsigned      MEM_AW      = 21,
  parameter int unsigned      DATA_W      = 8,
  parameter logic [CMD_W-1:0] RD_OP       = 8'h03,
  parameter int unsigned      SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic sclk_i,
  input  logic sdi_i,
  input  logic pause_i,
  output logic sdo_o,
  output logic sdo_oe_o
);
  localparam int unsigned BP_W = $clog2(DATA_W);

  logic              cs_s, sck_s, sdi_s;
  logic              cs_q, sck_q, armed_q;
  logic              sck_rise, sck_fall, ev_ok;
  logic [MEM_AW-1:0] rom_addr;
  logic [DATA_W-1:0] rom_data;
  logic              out_bit, streaming;
  logic [BP_W-1:0]   bit_pos;

  spi_rom_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({cs_ni, sclk_i, sdi_i}),
    .q_o   ({cs_s, sck_s, sdi_s})
  );

  // armed only by a select falling edge seen after reset
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      cs_q    <= 1'b0;
      sck_q   <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      cs_q    <= cs_s;
      sck_q   <= sck_s;
      armed_q <= armed_q | (cs_q & ~cs_s);
    end

  assign sck_rise = sck_s & ~sck_q;
  assign sck_fall = ~sck_s & sck_q;
  assign ev_ok    = armed_q & ~cs_s & ~pause_i;

  spi_rom_array #(.MEM_AW(MEM_AW), .DATA_W(DATA_W)) u_array (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .addr_i(rom_addr),
    .data_o(rom_data)
  );

  spi_rom_engine #(.MEM_AW(MEM_AW), .DATA_W(DATA_W), .RD_OP(RD_OP)) u_engine (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (cs_s),
    .rise_i     (sck_rise & ev_ok),
    .fall_i     (sck_fall & ev_ok),
    .sdi_i      (sdi_s),
    .rom_data_i (rom_data),
    .rom_addr_o (rom_addr),
    .out_bit_o  (out_bit),
    .streaming_o(streaming),
    .bit_pos_o  (bit_pos)
  );

  assign sdo_o    = out_bit;
  assign sdo_oe_o = streaming & ~cs_s & ~pause_i;
endmodule

// File: rtl/spi_rom_reader_chk.sv
module spi_rom_reader_chk #(
  parameter int unsigned BP_W = 3
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            cs_ni,
  input logic            pause_i,
  input logic            sdo_o,
  input logic            sdo_oe_o,
  input logic            cs_s,
  input logic            armed_q,
  input logic            sck_fall,
  input logic [BP_W-1:0] bit_pos
);
  p_hiz_deselected_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cs_ni, 2) |-> !sdo_oe_o);

  p_quiet_unarmed_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed_q |-> !sdo_oe_o);

  p_out_on_fall_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sdo_o) |-> ($past(sck_fall) || $past(cs_s)));

  p_pause_hiz_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pause_i |-> !sdo_oe_o);

  p_pause_freeze_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pause_i && !cs_s) |=> ($stable(bit_pos) && $stable(sdo_o)));
endmodule

bind spi_rom_reader spi_rom_reader_chk #(.BP_W(BP_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .cs_ni   (cs_ni),
  .pause_i (pause_i),
  .sdo_o   (sdo_o),
  .sdo_oe_o(sdo_oe_o),
  .cs_s    (cs_s),
  .armed_q (armed_q),
  .sck_fall(sck_fall),
  .bit_pos (bit_pos)
);

// File: tb/sim_spi_rom_reader.sv
`timescale 1ns/1ps
module sim_spi_rom_reader;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b0;
  logic sclk = 1'b0;
  logic sdi = 1'b0;
  logic pause = 1'b0;
  logic sdo, sdo_oe;

  int n_run = 0;
  int n_fail = 0;
  logic [7:0] exp_q[$];
  bit mon_en = 1'b0;
  int mon_bits = 0;
  logic [7:0] mon_byte = '0;
  string cur_tag = "";
  int oe_cnt = 0;

  always #5 clk = ~clk;

  spi_rom_reader u0 (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .cs_ni   (cs_n),
    .sclk_i  (sclk),
    .sdi_i   (sdi),
    .pause_i (pause),
    .sdo_o   (sdo),
    .sdo_oe_o(sdo_oe)
  );

  always @(posedge clk) oe_cnt <= oe_cnt + int'(sdo_oe);

  function automatic logic [7:0] exp_byte(input logic [20:0] a);
    return a[7:0] ^ a[15:8] ^ {3'b000, a[20:16]} ^ 8'h5A;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    sclk = 1'b0;
    sdi  = b;
    tick(HALF);
    sclk = 1'b1;
    tick(HALF);
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
  endtask

  task automatic send_addr(input logic [23:0] a);
    for (int i = 23; i >= 0; i--) send_bit(a[i]);
  endtask

  task automatic do_pause();
    mon_en = 1'b0;
    pause  = 1'b1;
    tick(2);
    check("R10 output released in pause", 32'(sdo_oe), 32'd0);
    repeat (3) begin
      sclk = 1'b0;
      sdi  = 1'($urandom);
      tick(HALF);
      sclk = 1'b1;
      tick(HALF);
    end
    tick(2);
    pause  = 1'b0;
    mon_en = 1'b1;
    tick(2);
  endtask

  // scoreboard driver: expected bytes go into exp_q before clocking
  task automatic do_read(input bit m3, input logic [23:0] adr, input int nb,
                         input int pause_at, input string tag);
    cur_tag = tag;
    for (int i = 0; i < nb; i++) exp_q.push_back(exp_byte(adr[20:0] + 21'(i)));
    sclk = m3;
    tick(4);
    cs_n = 1'b0;
    tick(HALF);
    send_byte(8'h03);
    send_addr(adr);
    mon_bits = 0;
    mon_en = 1'b1;
    for (int b = 0; b < nb * 8; b++) begin
      if (b == pause_at) do_pause();
      send_bit(1'b0);
    end
    mon_en = 1'b0;
    if (!m3) sclk = 1'b0;
    tick(HALF);
    cs_n = 1'b1;
    tick(4);
    check({tag, " / R1 released after deselect"}, 32'(sdo_oe), 32'd0);
    check({tag, " / bytes left unread"}, 32'(exp_q.size()), 32'd0);
    exp_q.delete();
  endtask

  // scoreboard monitor
  always @(posedge sclk) begin
    if (mon_en) begin
      check({cur_tag, " / R5 output enabled on data bit"}, 32'(sdo_oe), 32'd1);
      mon_byte = {mon_byte[6:0], sdo};
      mon_bits++;
      if (mon_bits == 8) begin
        mon_bits = 0;
        if (exp_q.size() == 0) begin
          check({cur_tag, " / unexpected byte"}, 32'(mon_byte), 32'hFFFF_FFFF);
        end else begin
          check({cur_tag, " / R11 byte value"}, 32'(mon_byte), 32'(exp_q.pop_front()));
        end
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : stim
    int snap;
    tick(5);
    rst_n = 1'b1;
    tick(4);
    check("R1 reset output enable", 32'(sdo_oe), 32'd0);
    check("R1 reset data out", 32'(sdo), 32'd0);

    // R2: select held low since reset, command must be refused
    snap = oe_cnt;
    send_byte(8'h03);
    send_addr(24'h000040);
    for (int i = 0; i < 16; i++) send_bit(1'b0);
    sclk = 1'b0;
    tick(HALF);
    check("R2 no command before select edge", 32'(oe_cnt - snap), 32'd0);
    cs_n = 1'b1;
    tick(HALF);

    // R3 R5 R7 R11 mode 0 from address zero
    do_read(1'b0, 24'h000000, 3, -1, "R3 R7 mode0 base read");

    // R4 unknown opcode
    snap = oe_cnt;
    sclk = 1'b0;
    cs_n = 1'b0;
    tick(HALF);
    send_byte(8'h0B);
    send_addr(24'h000100);
    for (int i = 0; i < 16; i++) send_bit(1'b1);
    sclk = 1'b0;
    tick(HALF);
    check("R4 other opcode ignored", 32'(oe_cnt - snap), 32'd0);
    cs_n = 1'b1;
    tick(HALF);

    // R1 abandon mid-address, then a clean read
    cs_n = 1'b0;
    tick(HALF);
    send_byte(8'h03);
    for (int i = 0; i < 10; i++) send_bit(1'b1);
    sclk = 1'b0;
    tick(HALF);
    cs_n = 1'b1;
    tick(HALF);
    do_read(1'b0, 24'h000123, 2, -1, "R1 read after abandoned command");

    do_read(1'b0, 24'h1FFFFE, 4, -1, "R8 wrap at top");
    do_read(1'b0, 24'hE00010, 2, -1, "R6 upper address bits ignored");
    do_read(1'b1, 24'h0ABCDE, 3, -1, "R9 idle-high clock");
    do_read(1'b0, 24'h012345, 2, 3, "R10 pause mid-byte mode0");
    do_read(1'b1, 24'h1FFFFF, 3, 12, "R10 R9 pause mode3 across wrap");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule